// File: doc/BRIEF.md
# Round-Trip Channel Delay Meter

This unit measures the one-way latency of a synchronization channel while user data keeps flowing. When a measurement is requested, the unit offers a delay-probe command to the forward channel. Counting starts in the cycle that command is accepted. The far end sends the probe straight back, marked as an echo. When the echo arrives, the unit halves the counted round trip to get the one-way delay in reference-clock cycles. It keeps the bit that the halving drops as a half-cycle flag. The result is then used to preload the far end's real-time register.

Every end carries one instance, so either end can start a measurement. The same instance also returns probes that the far end sends to it. Those fresh probes go onto the reverse channel through a valid/ready loopback port, whatever the local measurement is doing. The probe-offer port is valid/ready as well. Valid stays asserted until ready accepts the transfer, and the count starts only at that acceptance, so back-pressure never adds to the measured delay. The loopback port has a single pending slot. Probes that arrive while one is already pending merge into it. If no echo comes back within a limit captured at start, the unit gives up and raises a timeout flag in place of a result.

Top module: `rtd_meter`

## Requirements
- R1: After reset the unit is idle: `busy_o`, `probe_valid_o`, `loop_valid_o`, `res_valid_o` and `timeout_o` are all 0.
- R2: A `start_i` pulse while idle raises `probe_valid_o` in the next cycle. It stays high until a cycle in which `probe_ready_i` is 1. That cycle is the probe handshake, and `probe_valid_o` is 0 after it.
- R3: Let R (R ≥ 1) be the number of clock edges from the probe-handshake edge to the edge that samples `rx_strobe_i`=1 with `rx_echo_i`=1. Then `res_delay_o` = R shifted right by one, and `res_valid_o` rises at that edge.
- R4: `res_half_o` equals bit 0 of R, which is the bit the halving drops.
- R5: An `rx_strobe_i` with `rx_echo_i`=0 is a fresh probe. It raises `loop_valid_o` in the next cycle, and `loop_valid_o` holds until `loop_ready_i` is 1. This happens in any state and leaves the running measurement's result unchanged.
- R6: An echo (`rx_echo_i`=1) that arrives while the unit is not waiting for its own return has no effect on `res_valid_o`, `res_delay_o` or `timeout_o`.
- R7: A `start_i` while `busy_o` is 1 is ignored. No second probe is offered, and the running count continues.
- R8: `timeout_lim_i` is captured at start. If no echo has come by the edge where R would reach that limit, the unit returns to idle with `timeout_o`=1 and `res_valid_o`=0. An echo at R equal to the limit still counts as a result.
- R9: A new accepted start clears `res_valid_o` and `timeout_o` at its edge. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a measurement |
| timeout_lim_i | input | CNT_W | Round-trip limit in cycles, captured at start |
| probe_valid_o | output | 1 | Delay probe offered to the forward channel |
| probe_ready_i | input | 1 | Forward channel accepts the probe |
| rx_strobe_i | input | 1 | A delay-probe command arrived from the far end |
| rx_echo_i | input | 1 | 1: the arriving command is our own returned echo; 0: a fresh far-end probe |
| loop_valid_o | output | 1 | A fresh probe waits to be sent back on the reverse channel |
| loop_ready_i | input | 1 | Reverse channel accepts the looped probe |
| busy_o | output | 1 | A measurement is in progress |
| res_valid_o | output | 1 | Result is valid, held until the next start |
| res_delay_o | output | CNT_W | One-way delay in whole cycles |
| res_half_o | output | 1 | Residual half cycle of the round trip |
| timeout_o | output | 1 | The last measurement ended without an echo |

## Verification
Round trips of 1, 7 and 10 cycles cover the halving with an odd and an even count and at the smallest count. With them an off-by-one in the count start, the shift or the half-flag bit gives a visibly wrong answer. A probe held back by a deasserted ready shows that the count starts at the handshake and not at the request. A fresh far-end probe, a stray echo and a repeated start are injected in the middle of a measurement. Each must leave the final delay unchanged, and the looped probe must be held under back-pressure. A run with no echo checks both sides of the timeout edge, and a following measurement checks that the timeout flag is cleared.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } rtd_state_e;
endpackage

// File: rtl/rtd_loop.sv
module rtd_loop (
  input  logic clk,
  input  logic rst_n,
  input  logic fresh_i,
  input  logic ready_i,
  output logic valid_o
);
  logic pend_q;

  // arrivals merge into a single pending slot; a new arrival wins over a drain
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q && !ready_i) || fresh_i;
  end

  assign valid_o = pend_q;
endmodule

// File: rtl/rtd_ctrl.sv
module rtd_ctrl
  import rtd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             probe_ready_i,
  input  logic             echo_i,
  output logic             probe_valid_o,
  output logic             busy_o,
  output logic             res_valid_o,
  output logic [CNT_W-1:0] res_delay_o,
  output logic             res_half_o,
  output logic             timeout_o
);
  localparam int RT_W = CNT_W + 1;

  rtd_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [RT_W-1:0]  rt;
  logic             reached;

  // round trip in edges, counting the current one
  assign rt      = {1'b0, cnt_q} + RT_W'(1);
  assign reached = (rt >= {1'b0, lim_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      lim_q       <= '0;
      res_valid_o <= 1'b0;
      res_delay_o <= '0;
      res_half_o  <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q        <= ST_SEND;
          lim_q       <= lim_i;
          res_valid_o <= 1'b0;
          timeout_o   <= 1'b0;
        end
        ST_SEND: if (probe_ready_i) begin
          st_q  <= ST_WAIT;
          cnt_q <= '0;
        end
        ST_WAIT: begin
          if (echo_i) begin
            st_q        <= ST_IDLE;
            res_valid_o <= 1'b1;
            res_delay_o <= rt[RT_W-1:1];
            res_half_o  <= rt[0];
          end else if (reached) begin
            st_q      <= ST_IDLE;
            timeout_o <= 1'b1;
          end else begin
            cnt_q <= rt[CNT_W-1:0];
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign probe_valid_o = (st_q == ST_SEND);
  assign busy_o        = (st_q != ST_IDLE);
endmodule

// File: rtl/rtd_meter.sv
module rtd_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] timeout_lim_i,
  output logic             probe_valid_o,
  input  logic             probe_ready_i,
  input  logic             rx_strobe_i,
  input  logic             rx_echo_i,
  output logic             loop_valid_o,
  input  logic             loop_ready_i,
  output logic             busy_o,
  output logic             res_valid_o,
  output logic [CNT_W-1:0] res_delay_o,
  output logic             res_half_o,
  output logic             timeout_o
);
  logic fresh;
  logic echo;

  assign fresh = rx_strobe_i && !rx_echo_i;
  assign echo  = rx_strobe_i &&  rx_echo_i;

  rtd_loop u_loop (
    .clk     (clk),
    .rst_n   (rst_n),
    .fresh_i (fresh),
    .ready_i (loop_ready_i),
    .valid_o (loop_valid_o)
  );

  rtd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .lim_i         (timeout_lim_i),
    .probe_ready_i (probe_ready_i),
    .echo_i        (echo),
    .probe_valid_o (probe_valid_o),
    .busy_o        (busy_o),
    .res_valid_o   (res_valid_o),
    .res_delay_o   (res_delay_o),
    .res_half_o    (res_half_o),
    .timeout_o     (timeout_o)
  );
endmodule

// File: rtl/rtd_meter_chk.sv
module rtd_meter_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             probe_valid_o,
  input logic             probe_ready_i,
  input logic             rx_strobe_i,
  input logic             rx_echo_i,
  input logic             loop_valid_o,
  input logic             loop_ready_i,
  input logic             busy_o,
  input logic             res_valid_o,
  input logic [CNT_W-1:0] res_delay_o,
  input logic             timeout_o
);
  a_r2_probe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid_o && !probe_ready_i |=> probe_valid_o);

  a_r2_probe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid_o && probe_ready_i |=> !probe_valid_o);

  a_r5_loop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    loop_valid_o && !loop_ready_i |=> loop_valid_o);

  a_r5_loop_raise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe_i && !rx_echo_i |=> loop_valid_o);

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !probe_valid_o |=> !probe_valid_o);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid_o && timeout_o));

  a_r3_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !start_i |=> res_valid_o && $stable(res_delay_o));
endmodule

bind rtd_meter rtd_meter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rtd_meter_bench.sv
module rtd_meter_bench;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] lim = W'(40);
  logic         probe_valid_o, probe_ready_i = 1'b0;
  logic         rx_strobe_i = 1'b0, rx_echo_i = 1'b0;
  logic         loop_valid_o, loop_ready_i = 1'b0;
  logic         busy_o, res_valid_o, res_half_o, timeout_o;
  logic [W-1:0] res_delay_o;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  rtd_meter #(.CNT_W(W)) u_rtd_meter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .timeout_lim_i(lim),
    .probe_valid_o(probe_valid_o), .probe_ready_i(probe_ready_i),
    .rx_strobe_i(rx_strobe_i), .rx_echo_i(rx_echo_i),
    .loop_valid_o(loop_valid_o), .loop_ready_i(loop_ready_i),
    .busy_o(busy_o), .res_valid_o(res_valid_o), .res_delay_o(res_delay_o),
    .res_half_o(res_half_o), .timeout_o(timeout_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_rx(input logic e);
    rx_strobe_i = 1'b1; rx_echo_i = e;
    @(negedge clk);
    rx_strobe_i = 1'b0; rx_echo_i = 1'b0;
  endtask

  // hold: cycles of probe back-pressure; side: 0 none, 1 fresh probe, 2 stray start, 3 early echo
  task automatic measure(input int r, input int hold, input int side);
    @(negedge clk);
    start_i = 1'b1; probe_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 probe offered", probe_valid_o, 1);
    chk("R9 result cleared at start", res_valid_o, 0);
    for (int i = 0; i < hold; i++) begin
      if (side == 3 && i == 0) pulse_rx(1'b1);
      else @(negedge clk);
      chk("R2 probe held", probe_valid_o, 1);
    end
    probe_ready_i = 1'b1;
    @(negedge clk);
    probe_ready_i = 1'b0;
    chk("R2 probe dropped", probe_valid_o, 0);
    chk("R7 busy in wait", busy_o, 1);
    for (int i = 0; i < r - 1; i++) begin
      if (side == 1 && i == 0) begin
        loop_ready_i = 1'b0;
        pulse_rx(1'b0);
        chk("R5 loop raised", loop_valid_o, 1);
      end else if (side == 2 && i == 0) begin
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R7 no second probe", probe_valid_o, 0);
      end else @(negedge clk);
    end
    pulse_rx(1'b1);
    chk("R3 valid", res_valid_o, 1);
    chk("R3 delay", res_delay_o, r >> 1);
    chk("R4 half", res_half_o, r & 1);
    chk("R9 no timeout", timeout_o, 0);
    if (side == 1) begin
      chk("R5 loop held", loop_valid_o, 1);
      loop_ready_i = 1'b1;
      @(negedge clk);
      loop_ready_i = 1'b0;
      chk("R5 loop drained", loop_valid_o, 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 probe", probe_valid_o, 0);
    chk("R1 loop", loop_valid_o, 0);
    chk("R1 valid", res_valid_o, 0);
    chk("R1 timeout", timeout_o, 0);
  endtask

  task automatic t_stray_echo();
    logic [W-1:0] d;
    d = res_delay_o;
    pulse_rx(1'b1);
    @(negedge clk);
    chk("R6 valid kept", res_valid_o, 1);
    chk("R6 delay kept", res_delay_o, d);
    chk("R6 no timeout", timeout_o, 0);
  endtask

  task automatic t_timeout(input int l);
    lim = W'(l);
    @(negedge clk);
    start_i = 1'b1; probe_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    probe_ready_i = 1'b0;
    lim = W'(3);
    for (int i = 0; i < l - 1; i++) @(negedge clk);
    chk("R8 not yet", timeout_o, 0);
    chk("R8 still busy", busy_o, 1);
    @(negedge clk);
    chk("R8 timeout", timeout_o, 1);
    chk("R8 no result", res_valid_o, 0);
    chk("R8 idle", busy_o, 0);
    lim = W'(40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    measure(7, 0, 0);
    measure(10, 3, 0);
    measure(1, 0, 0);
    measure(9, 2, 1);
    measure(6, 0, 2);
    measure(5, 2, 3);
    t_stray_echo();
    t_timeout(12);
    measure(4, 0, 0);
    chk("R9 timeout cleared", timeout_o, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule